// File: doc/BRIEF.md
# Multicycle Shared-ALU Processor

A 32-bit processor core that runs a small load/store instruction subset: word load, word store, five register-to-register operations (add, subtract, and, or, signed set-less-than), branch-if-equal and an absolute jump. One memory array holds both code and data. One ALU does every calculation, including the PC increment and the branch target. A controller steps each instruction through only the phases it needs, so an instruction takes 2 to 5 cycles. Values that cross a cycle boundary are held in internal registers: an instruction latch, a memory data latch, two operand latches and an ALU result latch.

The memory is filled through a load port while reset is held. After reset is released the core fetches from byte address 0. Completed stores appear on a store-observation port during the cycle that writes memory. A one-cycle retire pulse marks the last cycle of every instruction, so cycles per instruction can be counted from outside the core.

Controller states and transitions:
- `S_FETCH` always goes to `S_DECODE`.
- `S_DECODE` goes to `S_MEMADR` for a load or store, `S_EXEC` for a register operation, `S_BRANCH` for a branch, `S_JUMP` for a jump, and `S_FETCH` for any other opcode.
- `S_MEMADR` goes to `S_MEMRD` for a load and `S_MEMWR` for a store.
- `S_MEMRD` goes to `S_MEMWB`.
- `S_EXEC` goes to `S_RWB`.
- `S_MEMWB`, `S_MEMWR`, `S_RWB`, `S_BRANCH` and `S_JUMP` all return to `S_FETCH`.

Top module: `mc_cpu`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 and the controller to the fetch state. While `rst` is high, `retire` and `st_valid` stay low, and a high `ld_en` writes `ld_data` into memory word `ld_addr`.
- R2: Every instruction begins with a fetch cycle and a decode cycle. The fetch cycle latches the word at byte address PC (word index PC[AW+1:2]) and advances the PC by 4 through the shared ALU.
- R3: Instruction lengths in cycles are: load 5, store 4, register operation 4, branch 3, jump 3, unrecognised opcode 2.
- R4: A load (opcode bits [31:26] = 0x23) writes the memory word at rs + sign-extended imm16 into register rt. The fields are rs = [25:21], rt = [20:16] and imm16 = [15:0].
- R5: A store (opcode 0x2B) writes register rt to memory at rs + sign-extended imm16. In that cycle, `st_valid` is high, `st_addr` carries the byte address and `st_data` carries the word.
- R6: A register operation (opcode 0x00) writes rs OP rt into rd = [15:11]. The function field [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed less-than (result 1 or 0).
- R7: A branch (opcode 0x04) that finds rs equal to rt loads the PC with PC+4 + (sign-extended imm16 << 2). Otherwise execution continues at PC+4. Backward offsets work.
- R8: A jump (opcode 0x02) loads the PC with {PC+4 [31:28], target [25:0], 2'b00}.
- R9: Any other opcode returns to fetch straight after decode and writes no register, no memory and no PC.
- R10: Register 0 always reads as zero, and writes to it are discarded.
- R11: `retire` is high for exactly one cycle, in the final cycle of each instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Memory preload write enable |
| ld_addr | input | AW | Preload word index |
| ld_data | input | 32 | Preload word |
| pc | output | 32 | Current program counter |
| retire | output | 1 | Last cycle of an instruction |
| st_valid | output | 1 | A store writes memory this cycle |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data |

## Verification
The assertions assume that `ld_en` is raised only while `rst` is held. A preload that overlaps execution would race the core's own memory traffic, and the state-sequence and store-slot properties take no account of it. The bench drives the load port only inside reset windows, and never changes memory once a run has started.

The assertions also assume that every memory access falls inside the array, since a wrapped address would alias code. The test program keeps its code below byte 0x80 and its data at 0x300 and above, and it ends in a one-instruction backward branch, so fetch never runs off the end of the code.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN = 32;

    typedef enum logic [3:0] {
        S_FETCH,
        S_DECODE,
        S_MEMADR,
        S_MEMRD,
        S_MEMWB,
        S_MEMWR,
        S_EXEC,
        S_RWB,
        S_BRANCH,
        S_JUMP
    } state_t;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    // ALU operation class from the controller
    localparam logic [1:0] AOP_ADD  = 2'b00;
    localparam logic [1:0] AOP_SUB  = 2'b01;
    localparam logic [1:0] AOP_FUNC = 2'b10;

    typedef struct packed {
        logic       iord;
        logic       irwrite;
        logic       pcwrite;
        logic       pcwritecond;
        logic       srca;
        logic [1:0] srcb;
        logic [1:0] aluop;
        logic [1:0] pcsrc;
        logic       regdst;
        logic       regwrite;
        logic       memread;
        logic       memwrite;
        logic       memtoreg;
    } ctl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [1:0]      aluop,
    input  logic [5:0]      funct,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    typedef enum logic [2:0] {F_ADD, F_SUB, F_AND, F_OR, F_SLT} fn_t;
    fn_t fn;

    always_comb begin
        unique case (aluop)
            AOP_SUB:  fn = F_SUB;
            AOP_FUNC: begin
                unique case (funct)
                    6'h22:   fn = F_SUB;
                    6'h24:   fn = F_AND;
                    6'h25:   fn = F_OR;
                    6'h2A:   fn = F_SLT;
                    default: fn = F_ADD;
                endcase
            end
            default:  fn = F_ADD;
        endcase
    end

    always_comb begin
        unique case (fn)
            F_SUB:   y = a - b;
            F_AND:   y = a & b;
            F_OR:    y = a | b;
            F_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic [RW-1:0]   ra1,
    input  logic [RW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [RW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_mem.sv
module mc_mem
    import mc_pkg::*;
#(
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    output state_t     state,
    output ctl_t       ctl,
    output logic       retire
);
    state_t nxt;
    logic   known;

    assign known = (opcode == OP_LOAD) || (opcode == OP_STORE) ||
                   (opcode == OP_RTYPE) || (opcode == OP_BEQ) ||
                   (opcode == OP_JUMP);

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = S_FETCH;
        unique case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                case (opcode)
                    OP_LOAD, OP_STORE: nxt = S_MEMADR;
                    OP_RTYPE:          nxt = S_EXEC;
                    OP_BEQ:            nxt = S_BRANCH;
                    OP_JUMP:           nxt = S_JUMP;
                    default:           nxt = S_FETCH;
                endcase
            end
            S_MEMADR: nxt = (opcode == OP_LOAD) ? S_MEMRD : S_MEMWR;
            S_MEMRD:  nxt = S_MEMWB;
            S_EXEC:   nxt = S_RWB;
            default:  nxt = S_FETCH;
        endcase
    end

    always_comb begin
        ctl    = '0;
        retire = 1'b0;
        unique case (state)
            S_FETCH: begin
                ctl.memread = 1'b1;
                ctl.irwrite = 1'b1;
                ctl.srcb    = 2'b01;
                ctl.aluop   = AOP_ADD;
                ctl.pcwrite = 1'b1;
                ctl.pcsrc   = 2'b00;
            end
            S_DECODE: begin
                ctl.srcb = 2'b11;
                retire   = !known;
            end
            S_MEMADR: begin
                ctl.srca = 1'b1;
                ctl.srcb = 2'b10;
            end
            S_MEMRD: begin
                ctl.memread = 1'b1;
                ctl.iord    = 1'b1;
            end
            S_MEMWB: begin
                ctl.regwrite = 1'b1;
                ctl.memtoreg = 1'b1;
                retire       = 1'b1;
            end
            S_MEMWR: begin
                ctl.memwrite = 1'b1;
                ctl.iord     = 1'b1;
                retire       = 1'b1;
            end
            S_EXEC: begin
                ctl.srca  = 1'b1;
                ctl.aluop = AOP_FUNC;
            end
            S_RWB: begin
                ctl.regwrite = 1'b1;
                ctl.regdst   = 1'b1;
                retire       = 1'b1;
            end
            S_BRANCH: begin
                ctl.srca        = 1'b1;
                ctl.aluop       = AOP_SUB;
                ctl.pcwritecond = 1'b1;
                ctl.pcsrc       = 2'b01;
                retire          = 1'b1;
            end
            S_JUMP: begin
                ctl.pcwrite = 1'b1;
                ctl.pcsrc   = 2'b10;
                retire      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
    import mc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_addr,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] pc,
    output logic            retire,
    output logic            st_valid,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data
);
    logic [XLEN-1:0] ir, mdr, a_q, b_q, aluout;
    logic [XLEN-1:0] mem_rd, rf_rd1, rf_rd2, alu_a, alu_b, alu_y, pc_nx, sext;
    logic [XLEN-1:0] maddr;
    logic            zero, pc_we;
    state_t          state;
    ctl_t            ctl;

    mc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .opcode(ir[31:26]),
        .state(state), .ctl(ctl), .retire(retire)
    );

    assign maddr = ctl.iord ? aluout : pc;

    mc_mem #(.AW(AW)) u_mem (
        .clk(clk),
        .we(ld_en | ctl.memwrite),
        .waddr(ld_en ? ld_addr : maddr[AW+1:2]),
        .wdata(ld_en ? ld_data : b_q),
        .raddr(maddr[AW+1:2]),
        .rdata(mem_rd)
    );

    mc_regfile #(.NREG(32)) u_rf (
        .clk(clk),
        .ra1(ir[25:21]), .ra2(ir[20:16]),
        .rd1(rf_rd1), .rd2(rf_rd2),
        .we(ctl.regwrite),
        .wa(ctl.regdst ? ir[15:11] : ir[20:16]),
        .wd(ctl.memtoreg ? mdr : aluout)
    );

    assign sext  = {{(XLEN-16){ir[15]}}, ir[15:0]};
    assign alu_a = ctl.srca ? a_q : pc;

    always_comb begin
        unique case (ctl.srcb)
            2'b00:   alu_b = b_q;
            2'b01:   alu_b = 32'd4;
            2'b10:   alu_b = sext;
            default: alu_b = sext << 2;
        endcase
    end

    mc_alu u_alu (
        .a(alu_a), .b(alu_b), .aluop(ctl.aluop), .funct(ir[5:0]),
        .y(alu_y), .zero(zero)
    );

    always_comb begin
        unique case (ctl.pcsrc)
            2'b01:   pc_nx = aluout;
            2'b10:   pc_nx = {pc[31:28], ir[25:0], 2'b00};
            default: pc_nx = alu_y;
        endcase
    end

    assign pc_we = ctl.pcwrite | (ctl.pcwritecond & zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            mdr    <= '0;
            a_q    <= '0;
            b_q    <= '0;
            aluout <= '0;
        end else begin
            if (pc_we)       pc  <= pc_nx;
            if (ctl.irwrite) ir  <= mem_rd;
            if (ctl.memread) mdr <= mem_rd;
            a_q    <= rf_rd1;
            b_q    <= rf_rd2;
            aluout <= alu_y;
        end
    end

    assign st_valid = ctl.memwrite;
    assign st_addr  = aluout;
    assign st_data  = b_q;
endmodule

// File: rtl/mc_cpu_chk.sv
module mc_cpu_chk
    import mc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input state_t          state,
    input logic [5:0]      opcode,
    input logic [XLEN-1:0] pc,
    input logic            retire,
    input logic            st_valid
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && state == S_FETCH));

    // R2
    fetch_decode_chk: assert property (@(posedge clk) disable iff (rst)
        state == S_FETCH |=> state == S_DECODE);

    // R4
    load_path_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && opcode == OP_LOAD) |=> state == S_MEMADR);

    // R5
    store_slot_chk: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> $past(state) == S_MEMADR);

    // R9
    unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && opcode != OP_LOAD && opcode != OP_STORE &&
         opcode != OP_RTYPE && opcode != OP_BEQ && opcode != OP_JUMP)
        |=> state == S_FETCH);

    // R11
    retire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        retire |=> (state == S_FETCH && !retire));

    // R7
    pc_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc) |-> ($past(state) == S_FETCH ||
                          $past(state) == S_BRANCH ||
                          $past(state) == S_JUMP));

    // R8
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);
endmodule

bind mc_cpu mc_cpu_chk u_chk (
    .clk(clk), .rst(rst), .state(state), .opcode(ir[31:26]),
    .pc(pc), .retire(retire), .st_valid(st_valid)
);

// File: tb/mc_cpu_test.sv
module mc_cpu_test;
    localparam int CLK_NS = 10;
    localparam int AW     = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [31:0]   pc, st_addr, st_data;
    logic          retire, st_valid;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int          exp_cyc[$];
    string       cyc_req[$];
    logic [63:0] exp_st[$];
    string       st_req[$];

    mc_cpu #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .pc(pc), .retire(retire), .st_valid(st_valid),
        .st_addr(st_addr), .st_data(st_data)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic load_word(input int byte_addr, input logic [31:0] w);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = AW'(byte_addr >> 2);
        ld_data = w;
    endtask

    task automatic exp_retire(input int n, input string req);
        exp_cyc.push_back(n);
        cyc_req.push_back(req);
    endtask
    task automatic exp_store(input logic [31:0] a, input logic [31:0] d, input string req);
        exp_st.push_back({a, d});
        st_req.push_back(req);
    endtask

    task automatic push_program_expectations();
        exp_retire(5, "R4"); exp_retire(5, "R4");
        for (int i = 0; i < 6; i++) exp_retire(4, "R6");
        for (int i = 0; i < 6; i++) exp_retire(4, "R5");
        exp_retire(3, "R7"); exp_retire(3, "R7");
        exp_retire(3, "R8");
        exp_retire(2, "R9");
        exp_retire(4, "R10"); exp_retire(4, "R10");
        exp_retire(5, "R4"); exp_retire(4, "R5");
        exp_retire(5, "R4"); exp_retire(4, "R5");
        exp_retire(3, "R7");
        exp_store(32'h310, 32'h4,        "R6");
        exp_store(32'h314, 32'hA,        "R6");
        exp_store(32'h318, 32'h5,        "R6");
        exp_store(32'h31C, 32'hFFFFFFFF, "R6");
        exp_store(32'h320, 32'h1,        "R6");
        exp_store(32'h324, 32'h0,        "R6");
        exp_store(32'h330, 32'h0,        "R10");
        exp_store(32'h334, 32'h4,        "R4");
        exp_store(32'h338, 32'hFFFFFFFD, "R4");
    endtask

    // Monitor: pops and compares expectations as results appear
    int  cnt = 0;
    bit  prev_ret = 0;
    always @(negedge clk) begin
        #1;
        if (rst) begin
            cnt = 0;
            prev_ret = 0;
        end else begin
            cnt++;
            if (retire) begin
                check(!prev_ret, "R11", "retire longer than one cycle", 32'(prev_ret), 32'h0);
                if (exp_cyc.size() > 0) begin
                    automatic int    e = exp_cyc.pop_front();
                    automatic string r = cyc_req.pop_front();
                    check(cnt == e, r, "R3 cycles per instruction", 32'(cnt), 32'(e));
                end
                cnt = 0;
            end
            prev_ret = retire;
            if (st_valid) begin
                if (exp_st.size() > 0) begin
                    automatic logic [63:0] e = exp_st.pop_front();
                    automatic string       r = st_req.pop_front();
                    check(st_addr == e[63:32], r, "store address", st_addr, e[63:32]);
                    check(st_data == e[31:0],  r, "store data",    st_data, e[31:0]);
                end else begin
                    check(1'b0, "R5", "unexpected store", st_addr, 32'h0);
                end
            end
        end
    end

    task automatic wait_drain();
        while (exp_cyc.size() != 0 || exp_st.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #1;
        // R1 reset state
        check(pc == 32'h0, "R1", "pc in reset", pc, 32'h0);
        check(!retire,     "R1", "retire in reset", 32'(retire), 32'h0);
        check(!st_valid,   "R1", "store in reset", 32'(st_valid), 32'h0);

        load_word(32'h00, enc_i(6'h23, 0, 1, 16'h300));
        load_word(32'h04, enc_i(6'h23, 0, 2, 16'h304));
        load_word(32'h08, enc_r(1, 2, 3, 6'h20));
        load_word(32'h0C, enc_r(1, 2, 4, 6'h22));
        load_word(32'h10, enc_r(1, 2, 5, 6'h24));
        load_word(32'h14, enc_r(1, 2, 6, 6'h25));
        load_word(32'h18, enc_r(2, 1, 7, 6'h2A));
        load_word(32'h1C, enc_r(1, 2, 8, 6'h2A));
        load_word(32'h20, enc_i(6'h2B, 0, 3, 16'h310));
        load_word(32'h24, enc_i(6'h2B, 0, 4, 16'h314));
        load_word(32'h28, enc_i(6'h2B, 0, 5, 16'h318));
        load_word(32'h2C, enc_i(6'h2B, 0, 6, 16'h31C));
        load_word(32'h30, enc_i(6'h2B, 0, 7, 16'h320));
        load_word(32'h34, enc_i(6'h2B, 0, 8, 16'h324));
        load_word(32'h38, enc_i(6'h04, 1, 2, 5));
        load_word(32'h3C, enc_i(6'h04, 1, 1, 2));
        load_word(32'h40, enc_i(6'h2B, 0, 1, 16'h328));
        load_word(32'h44, enc_i(6'h2B, 0, 1, 16'h328));
        load_word(32'h48, {6'h02, 26'h15});
        load_word(32'h4C, enc_i(6'h2B, 0, 1, 16'h32C));
        load_word(32'h50, enc_i(6'h2B, 0, 1, 16'h32C));
        load_word(32'h54, 32'hFC00_0000);
        load_word(32'h58, enc_r(1, 1, 0, 6'h20));
        load_word(32'h5C, enc_i(6'h2B, 0, 0, 16'h330));
        load_word(32'h60, enc_i(6'h23, 0, 9, 16'h310));
        load_word(32'h64, enc_i(6'h2B, 0, 9, 16'h334));
        load_word(32'h68, enc_i(6'h23, 3, 11, 16'h300));
        load_word(32'h6C, enc_i(6'h2B, 0, 11, 16'h338));
        load_word(32'h70, enc_i(6'h04, 0, 0, -1));
        load_word(32'h300, 32'h7);
        load_word(32'h304, 32'hFFFFFFFD);
        @(negedge clk);
        ld_en = 1'b0;

        push_program_expectations();
        @(negedge clk);
        rst = 1'b0;
        wait_drain();

        // R7 backward branch keeps execution inside the loop
        repeat (7) @(negedge clk);
        #1;
        check(pc == 32'h70 || pc == 32'h74, "R7", "loop pc", pc, 32'h70);
        repeat (4) @(negedge clk);
        #1;
        check(pc == 32'h70 || pc == 32'h74, "R7", "loop pc later", pc, 32'h74);

        // R1 reset in mid-run, then the whole program again
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(pc == 32'h0, "R1", "pc after mid-run reset", pc, 32'h0);
        check(!retire, "R1", "retire during mid-run reset", 32'(retire), 32'h0);
        push_program_expectations();
        @(negedge clk);
        rst = 1'b0;
        wait_drain();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d pending items", exp_cyc.size(), 0);
            finish_run();
        end
    end
endmodule